// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Guard

This block sits beside the command scheduler of one DIMM and decides, cycle by cycle, whether the candidate read or write command may go out now. The decision depends only on the gaps since the most recent read and the most recent write. It remembers when those two commands went out and which rank each targeted. It compares the cycles elapsed since each against five programmable minimum gaps, all counted in core clock cycles.

The five gaps are packed into one 32-bit configuration word. One word serves every port, so software programs each field with the largest value that any port needs. The grant is combinational from the tracking state and the candidate. A command counts as issued when `issue_i` is high at a rising clock edge, and the tracking state changes at that edge.

Top module: `cmd_turnaround_guard`

## Requirements
- R1: After reset, and before any command has been issued, `grant_o` is 1 for every candidate type and rank.
- R2: The configuration word is decoded as follows. Bits 3:0 hold the write-to-write gap. Bits 7:4 hold the read-to-read gap across ranks. Bits 11:8 hold the write-to-read gap on the same rank. Bits 15:12 hold the read-to-write gap. Bits 18:16 hold the write-to-read gap across ranks. Bits 31:19 have no effect on `grant_o`.
- R3: A read to the rank of the most recent write is granted only once the cycles since that write reach the same-rank write-to-read gap.
- R4: A read to a rank other than that of the most recent write is granted only once the cycles since that write reach the cross-rank write-to-read gap.
- R5: A read to a rank other than that of the most recent read waits for the read-to-read gap. A read to the same rank as the most recent read is not restricted by it.
- R6: A write, to any rank, is granted only once the cycles since the most recent read reach the read-to-write gap.
- R7: A write, to any rank, is granted only once the cycles since the most recent write reach the write-to-write gap.
- R8: Take a command issued at edge T. In the cycle after edge T+k-1, the elapsed count since that command is k. A gap of N therefore first allows the dependent command in the cycle after edge T+N-1, and a gap of 0 allows it at once.
- R9: `grant_o` follows a change of candidate type or rank within the same cycle, without waiting for a clock edge.
- R10: The elapsed counts saturate and do not wrap. Once a gap has been met, the grant stays allowed however long the block is idle.
- R11: Only the most recent read and the most recent write, together with their ranks, constrain the candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word_i | input | 32 | Packed turnaround gaps (layout in R2) |
| cand_is_wr_i | input | 1 | Candidate type: 1 for write, 0 for read |
| cand_rank_i | input | RANK_W | Candidate target rank |
| issue_i | input | 1 | Candidate is issued at this clock edge |
| grant_o | output | 1 | Candidate may be issued this cycle |

## Verification
The bound checker covers the gap rules on every cycle. It confirms that a zero configuration never blocks, that nothing blocks before the first command, and that each of the five pairings is refused one cycle after its first command whenever its gap is 2 or more. The exact release cycle at arbitrary gap values, rank-dependent selection after several commands, saturation over long idle periods, and the fact that reserved bits have no effect can only be shown by the bench. It uses directed gap probes and a random command stream compared against a timestamp model.

// File: rtl/turnaround_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, field positions and the decoded-gap record for the
// turnaround guard. Assumes every gap fits in GAP_W bits.
package turnaround_pkg;
    localparam int GAP_W      = 4;
    localparam int CFG_W      = 32;
    localparam int W2W_LSB    = 0;
    localparam int R2R_LSB    = 4;
    localparam int W2R_LSB    = 8;
    localparam int R2W_LSB    = 12;
    localparam int W2RX_LSB   = 16;
    localparam int W2RX_W     = 3;

    typedef logic [GAP_W-1:0] gap_t;

    typedef struct packed {
        gap_t wr_wr;       // write then write, any rank
        gap_t rd_rd_xr;    // read then read, other rank
        gap_t wr_rd_sr;    // write then read, same rank
        gap_t rd_wr;       // read then write, any rank
        gap_t wr_rd_xr;    // write then read, other rank
    } gaps_t;

    typedef enum logic {CMD_RD = 1'b0, CMD_WR = 1'b1} cmd_e;
endpackage

// File: rtl/ta_cfg_decode.sv
`timescale 1ns/1ps
// Module: splits the packed configuration word into the five gap fields.
// Assumes the reserved upper bits carry no meaning; they are dropped here.
module ta_cfg_decode
    import turnaround_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word_i,
    output gaps_t            gaps_o
);
    // Field extraction; the narrow cross-rank field is zero-extended.
    always_comb begin
        gaps_o.wr_wr    = cfg_word_i[W2W_LSB +: GAP_W];
        gaps_o.rd_rd_xr = cfg_word_i[R2R_LSB +: GAP_W];
        gaps_o.wr_rd_sr = cfg_word_i[W2R_LSB +: GAP_W];
        gaps_o.rd_wr    = cfg_word_i[R2W_LSB +: GAP_W];
        gaps_o.wr_rd_xr = {{(GAP_W-W2RX_W){1'b0}}, cfg_word_i[W2RX_LSB +: W2RX_W]};
    end
endmodule

// File: rtl/ta_cmd_tracker.sv
`timescale 1ns/1ps
// Module: remembers the rank of the last command of one type and counts the
// cycles since it, saturating at the largest count. Assumes record_i is
// high for exactly the edges on which such a command is issued.
module ta_cmd_tracker #(
    parameter int RANK_W = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              record_i,
    input  logic [RANK_W-1:0] rank_i,
    output logic              valid_o,
    output logic [RANK_W-1:0] rank_o,
    output logic [CNT_W-1:0]  elapsed_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Valid flag and rank of the most recent command of this type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            rank_o  <= '0;
        end else if (record_i) begin
            valid_o <= 1'b1;
            rank_o  <= rank_i;
        end
    end

    // Elapsed cycles: 1 in the cycle after issue, then counts up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_o <= '0;
        end else if (record_i) begin
            elapsed_o <= CNT_ONE;
        end else if (valid_o && (elapsed_o != CNT_MAX)) begin
            elapsed_o <= elapsed_o + CNT_ONE;
        end
    end
endmodule

// File: rtl/ta_rule_check.sv
`timescale 1ns/1ps
// Module: combinational grant decision from the two trackers, the decoded
// gaps and the candidate. Assumes the elapsed counts saturate at or above
// any gap value, so a plain compare is enough.
module ta_rule_check
    import turnaround_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  gaps_t             gaps_i,
    input  logic              cand_is_wr_i,
    input  logic [RANK_W-1:0] cand_rank_i,
    input  logic              rd_valid_i,
    input  logic [RANK_W-1:0] rd_rank_i,
    input  gap_t              rd_elapsed_i,
    input  logic              wr_valid_i,
    input  logic [RANK_W-1:0] wr_rank_i,
    input  gap_t              wr_elapsed_i,
    output logic              grant_o
);
    logic rd_ok;
    logic wr_ok;
    gap_t wr_need;

    // Gap against the last write: depends on type and, for reads, on rank.
    always_comb begin
        if (cand_is_wr_i)                  wr_need = gaps_i.wr_wr;
        else if (wr_rank_i == cand_rank_i) wr_need = gaps_i.wr_rd_sr;
        else                               wr_need = gaps_i.wr_rd_xr;
        wr_ok = !wr_valid_i || (wr_elapsed_i >= wr_need);
    end

    // Gap against the last read: writes always wait, reads only across ranks.
    always_comb begin
        if (!rd_valid_i)                   rd_ok = 1'b1;
        else if (cand_is_wr_i)             rd_ok = (rd_elapsed_i >= gaps_i.rd_wr);
        else if (rd_rank_i == cand_rank_i) rd_ok = 1'b1;
        else                               rd_ok = (rd_elapsed_i >= gaps_i.rd_rd_xr);
    end

    // Final grant needs both history constraints met.
    always_comb grant_o = rd_ok && wr_ok;
endmodule

// File: rtl/cmd_turnaround_guard.sv
`timescale 1ns/1ps
// Module: top of the turnaround guard for one DIMM. Tracks the last read and
// last write and grants the candidate when every applicable gap is met.
// Assumes one command at most per cycle and a configuration word held
// stable by software while traffic runs.
module cmd_turnaround_guard
    import turnaround_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word_i,
    input  logic              cand_is_wr_i,
    input  logic [RANK_W-1:0] cand_rank_i,
    input  logic              issue_i,
    output logic              grant_o
);
    localparam int NUM_TYPES = 2;

    gaps_t             gaps;
    logic              trk_valid   [NUM_TYPES];
    logic [RANK_W-1:0] trk_rank    [NUM_TYPES];
    gap_t              trk_elapsed [NUM_TYPES];

    ta_cfg_decode u_decode (
        .cfg_word_i (cfg_word_i),
        .gaps_o     (gaps)
    );

    // One tracker per command type; index 0 reads, index 1 writes.
    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_trk
        logic rec;
        always_comb rec = issue_i && (cand_is_wr_i == ((k == int'(CMD_WR)) ? 1'b1 : 1'b0));
        ta_cmd_tracker #(
            .RANK_W (RANK_W),
            .CNT_W  (GAP_W)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .record_i  (rec),
            .rank_i    (cand_rank_i),
            .valid_o   (trk_valid[k]),
            .rank_o    (trk_rank[k]),
            .elapsed_o (trk_elapsed[k])
        );
    end

    ta_rule_check #(.RANK_W(RANK_W)) u_rules (
        .gaps_i       (gaps),
        .cand_is_wr_i (cand_is_wr_i),
        .cand_rank_i  (cand_rank_i),
        .rd_valid_i   (trk_valid[int'(CMD_RD)]),
        .rd_rank_i    (trk_rank[int'(CMD_RD)]),
        .rd_elapsed_i (trk_elapsed[int'(CMD_RD)]),
        .wr_valid_i   (trk_valid[int'(CMD_WR)]),
        .wr_rank_i    (trk_rank[int'(CMD_WR)]),
        .wr_elapsed_i (trk_elapsed[int'(CMD_WR)]),
        .grant_o      (grant_o)
    );
endmodule

// File: rtl/ta_guard_checker.sv
`timescale 1ns/1ps
// Module: property checker bound to the guard top. Watches ports only and
// keeps one flag of its own: whether any command has been issued.
module ta_guard_checker #(
    parameter int RANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       cfg_word_i,
    input logic              cand_is_wr_i,
    input logic [RANK_W-1:0] cand_rank_i,
    input logic              issue_i,
    input logic              grant_o
);
    logic seen_cmd;

    // Records whether a command has gone out since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_cmd <= 1'b0;
        else if (issue_i) seen_cmd <= 1'b1;
    end

    a_r1_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_cmd |-> grant_o);

    a_r8_zero_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word_i[18:0] == 19'd0) |-> grant_o);

    a_r7_wr_wr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_i && cand_is_wr_i) && cand_is_wr_i &&
         cfg_word_i[3:0] >= 4'd2) |-> !grant_o);

    a_r6_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_i && !cand_is_wr_i) && cand_is_wr_i &&
         cfg_word_i[15:12] >= 4'd2) |-> !grant_o);

    a_r3_wr_rd_same: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_i && cand_is_wr_i) && !cand_is_wr_i &&
         cand_rank_i == $past(cand_rank_i) && cfg_word_i[11:8] >= 4'd2) |-> !grant_o);

    a_r4_wr_rd_other: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_i && cand_is_wr_i) && !cand_is_wr_i &&
         cand_rank_i != $past(cand_rank_i) && cfg_word_i[18:16] >= 3'd2) |-> !grant_o);

    a_r5_rd_rd_other: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_i && !cand_is_wr_i) && !cand_is_wr_i &&
         cand_rank_i != $past(cand_rank_i) && cfg_word_i[7:4] >= 4'd2) |-> !grant_o);
endmodule

bind cmd_turnaround_guard ta_guard_checker #(.RANK_W(RANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word_i   (cfg_word_i),
    .cand_is_wr_i (cand_is_wr_i),
    .cand_rank_i  (cand_rank_i),
    .issue_i      (issue_i),
    .grant_o      (grant_o)
);

// File: tb/cmd_turnaround_guard_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, plus a random stream checked
// against a timestamp model built from the requirements.
module cmd_turnaround_guard_tb_top;
    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_word;
    logic        cand_is_wr;
    logic [1:0]  cand_rank;
    logic        issue;
    logic        grant;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    // Reference model state: timestamps and ranks of the last read/write.
    bit m_rd_v, m_wr_v;
    int m_rd_t, m_wr_t, m_rd_rk, m_wr_rk;

    cmd_turnaround_guard #(.NUM_RANKS(NR)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_word_i   (cfg_word),
        .cand_is_wr_i (cand_is_wr),
        .cand_rank_i  (cand_rank),
        .issue_i      (issue),
        .grant_o      (grant)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int fld(input int lsb, input int w);
        return int'((cfg_word >> lsb) & ((32'd1 << w) - 1));
    endfunction

    // Expected grant from the timestamps, per R3 to R7.
    function automatic bit model_grant(input bit wr, input int rk);
        bit ok = 1'b1;
        if (wr) begin
            if (m_rd_v && (cyc - m_rd_t) < fld(12, 4)) ok = 1'b0;
            if (m_wr_v && (cyc - m_wr_t) < fld(0, 4))  ok = 1'b0;
        end else begin
            if (m_wr_v && (cyc - m_wr_t) < ((rk == m_wr_rk) ? fld(8, 4) : fld(16, 3))) ok = 1'b0;
            if (m_rd_v && rk != m_rd_rk && (cyc - m_rd_t) < fld(4, 4)) ok = 1'b0;
        end
        return ok;
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: grant=%b expected=%b at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; issue = 1'b0; cand_is_wr = 1'b0; cand_rank = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_rd_v = 1'b0; m_wr_v = 1'b0;
    endtask

    // One cycle: present the candidate, check against the model, maybe issue.
    task automatic step(input bit wr, input int rk, input bit do_iss,
                        input string tag, output logic g);
        @(negedge clk);
        cand_is_wr = wr; cand_rank = 2'(rk); issue = 1'b0;
        #1;
        g = grant;
        check(tag, g, model_grant(wr, rk));
        issue = do_iss;
        if (do_iss) begin
            if (wr) begin m_wr_v = 1'b1; m_wr_t = cyc; m_wr_rk = rk; end
            else    begin m_rd_v = 1'b1; m_rd_t = cyc; m_rd_rk = rk; end
        end
        @(posedge clk);
        #1 issue = 1'b0;
    endtask

    task automatic t_reset_state();
        logic g;
        cfg_word = 32'h0007_FFFF;
        do_reset();
        for (int r = 0; r < NR; r++) begin
            step(1'b0, r, 1'b0, "R1 read", g);  check("R1 read idle", g, 1'b1);
            step(1'b1, r, 1'b0, "R1 write", g); check("R1 write idle", g, 1'b1);
        end
    endtask

    // First command, then probe the second until its gap is met (R8 timing).
    task automatic gap_probe(input logic [31:0] cfg, input bit w1, input int r1,
                             input bit w2, input int r2, input int gap, input string tag);
        logic g;
        cfg_word = cfg;
        do_reset();
        step(w1, r1, 1'b1, tag, g);
        for (int k = 1; k <= gap + 1; k++) begin
            step(w2, r2, 1'b0, tag, g);
            check(tag, g, (k >= gap) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic t_pairings();
        gap_probe(32'hFFF8_0600, 1'b1, 0, 1'b0, 0, 6, "R3 wr-rd same rank");
        gap_probe(32'h0003_0F00, 1'b1, 0, 1'b0, 2, 3, "R4 wr-rd other rank");
        gap_probe(32'h0000_0040, 1'b0, 1, 1'b0, 3, 4, "R5 rd-rd other rank");
        gap_probe(32'h0000_00F0, 1'b0, 1, 1'b0, 1, 0, "R5 rd-rd same rank");
        gap_probe(32'h0000_7000, 1'b0, 0, 1'b1, 3, 7, "R6 rd-wr");
        gap_probe(32'h0000_0005, 1'b1, 2, 1'b1, 1, 5, "R7 wr-wr");
        gap_probe(32'hFFF8_0000, 1'b1, 0, 1'b0, 0, 0, "R2 reserved bits / R8 zero gap");
        gap_probe(32'h0000_0009, 1'b0, 0, 1'b1, 0, 0, "R2 field isolation");
    endtask

    // Candidate rank changes inside one cycle; grant must follow (R9).
    task automatic t_comb();
        logic g;
        cfg_word = 32'h0000_0800;
        do_reset();
        step(1'b1, 0, 1'b1, "R9 setup", g);
        @(negedge clk);
        cand_is_wr = 1'b0; cand_rank = 2'd0; #1;
        check("R9 same rank blocked", grant, 1'b0);
        cand_rank = 2'd1; #1;
        check("R9 other rank free", grant, 1'b1);
        cand_is_wr = 1'b1; #1;
        check("R9 write free", grant, 1'b1);
    endtask

    // Long idle after a maximum gap: grant must stay high (R10).
    task automatic t_saturate();
        logic g;
        cfg_word = 32'h0007_FFFF;
        do_reset();
        step(1'b1, 0, 1'b1, "R10 setup", g);
        for (int k = 1; k <= 40; k++) begin
            step(1'b1, 1, 1'b0, "R10", g);
            check("R10 saturation", g, (k >= 15) ? 1'b1 : 1'b0);
        end
    endtask

    // Only the last write counts: write r0, write r1, read r0 is cross-rank (R11).
    task automatic t_last_only();
        logic g;
        cfg_word = 32'h0002_0A00;
        do_reset();
        step(1'b1, 0, 1'b1, "R11", g);
        step(1'b1, 1, 1'b1, "R11", g);
        step(1'b0, 0, 1'b0, "R11", g); check("R11 k1", g, 1'b0);
        step(1'b0, 0, 1'b0, "R11", g); check("R11 k2 cross-rank gap", g, 1'b1);
    endtask

    task automatic t_random(input logic [31:0] cfg, input int n);
        logic g;
        cfg_word = cfg;
        do_reset();
        for (int i = 0; i < n; i++) begin
            bit wr = 1'($urandom_range(0, 1));
            int rk = int'($urandom_range(0, NR - 1));
            bit want = 1'($urandom_range(0, 1));
            @(negedge clk);
            cand_is_wr = wr; cand_rank = 2'(rk); #1;
            step(wr, rk, want && grant, "random stream", g);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; issue = 1'b0; cand_is_wr = 1'b0; cand_rank = '0; cfg_word = '0;
        t_reset_state();
        t_pairings();
        t_comb();
        t_saturate();
        t_last_only();
        t_random(32'h0000_0000, 1500);
        t_random(32'h0007_FFFF, 3000);
        t_random(32'h0003_5264, 3000);
        t_random(32'hABC1_3A82, 3000);
        finish_run();
    end
endmodule